// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous SRAM with a burst address counter and a pipelined read path. Every word is split into 9-bit byte lanes, each holding 8 data bits and 1 parity bit. The default is 2 lanes (18 bits) and 4 lanes (36 bits) is also supported. Addresses and write controls are captured on the rising clock edge, and the write then finishes from those captured values. Read data passes through one output register before it reaches the pins.

A burst can be opened by either of two active-low strobes. One is meant for a processor and one for a memory controller. The advance input then steps through the 4-word group that holds the start address. The step order is linear or interleaved, as chosen by an order input when the burst opens. Writes can target single lanes, or all lanes through a global write input. The output driver enable responds to the output-enable pin without waiting for a clock. A deselect turns the output driver off one clock edge later.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset before any access, `q_drv` is 0.
- R2: With `sel_n` low, a low `strobe_cpu_n` or `strobe_ctl_n` sampled at edge n starts a burst at `addr`. For a read, the word appears on `q` with `q_drv` high after edge n+1, and `q_drv` is not yet high for it after edge n.
- R3: When `burst_ilv` is 0 at burst start (linear order), each low `adv_n` moves the low 2 address bits to (start + beat) mod 4. The upper address bits stay fixed. Beat runs 0,1,2,3 and then wraps.
- R4: When `burst_ilv` is 1 at burst start (interleaved order), the low 2 address bits of beat b are start XOR b. The upper address bits stay fixed.
- R5: In a burst with no strobe and no deselect, a high `adv_n` repeats the access at the current address.
- R6: Lane i covers bits [9i+8:9i]. When `gwr_n` is high, a low `bwr_n[i]` writes lane i and leaves the other lanes unchanged. The cycle is a write when any `bwr_n` bit is low or `gwr_n` is low.
- R7: A low `gwr_n` writes every lane, whatever the value of `bwr_n`.
- R8: The cycle that starts a burst through `strobe_cpu_n` is always a read. The write controls in that cycle have no effect on memory.
- R9: `strobe_cpu_n` is ignored while `sel_n` is high, so a running burst continues as if the strobe were absent. `strobe_ctl_n` low with `sel_n` high is a deselect, which ends the burst.
- R10: A strobe during a burst restarts the burst from the new `addr`, with beat 0.
- R11: After a deselect or a write sampled at edge n, `q_drv` is 0 after edge n+1. A read at edge n-1 stays on the output after edge n.
- R12: `oe_n` high forces `q_drv` to 0 at once, without waiting for a clock edge. `oe_n` low lets a valid read drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| strobe_cpu_n | input | 1 | Processor-side burst start strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_ilv | input | 1 | Burst order at start: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| d | input | 9*LANES | Write data |
| q | output | 9*LANES | Read data |
| q_drv | output | 1 | High while the output drivers are on (low means high impedance) |

## Verification
An access sampled at edge n shows its read data on `q` after edge n+1. A write or deselect at edge n turns `q_drv` off after edge n+1. `oe_n` acts on `q_drv` without any edge. The bench's reference model holds the same one-cycle lag in its own stage variables and compares `q_drv` and `q` a quarter period after every rising edge. Directed checks sample each burst beat one edge after the beat was issued, which is how R3 and R4 are covered for all four start offsets. The output-enable checks look at `q_drv` a short delay after `oe_n` changes, with no clock edge in between.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANE_BITS = 9;
  localparam int BEAT_W = 2;

  // Low address bits of a burst beat: XOR pattern or wrapping add.
  function automatic logic [BEAT_W-1:0] burst_offset(
    input logic [BEAT_W-1:0] first,
    input logic [BEAT_W-1:0] beat,
    input logic              interleave
  );
    logic [BEAT_W-1:0] r;
    if (interleave) r = first ^ beat;
    else            r = first + beat;
    return r;
  endfunction
endpackage

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic              start_cpu,
  output logic              start_any,
  output logic              deselect,
  output logic              advance,
  output logic              busy,
  output logic              order_ilv,
  output logic              acc_go,
  output logic              acc_ro,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              start_ctl;
  logic [HI_W-1:0]   base_hi_q, base_hi_n;
  logic [BEAT_W-1:0] first_q, first_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic              ilv_q, ilv_n;
  logic              busy_q;

  // Strobe qualification: the processor strobe needs the select,
  // the controller strobe without select is a deselect.
  assign start_cpu = ~strobe_cpu_n & ~sel_n;
  assign start_ctl = ~strobe_ctl_n & ~sel_n;
  assign start_any = start_cpu | start_ctl;
  assign deselect  = sel_n & ~strobe_ctl_n;
  assign advance   = busy_q & ~start_any & ~deselect & ~adv_n;
  assign acc_go    = start_any | (busy_q & ~deselect);
  assign acc_ro    = start_cpu;
  assign busy      = busy_q;
  assign order_ilv = ilv_q;

  always_comb begin
    base_hi_n = base_hi_q;
    first_n   = first_q;
    beat_n    = beat_q;
    ilv_n     = ilv_q;
    if (start_any) begin
      base_hi_n = addr[ADDR_W-1:BEAT_W];
      first_n   = addr[BEAT_W-1:0];
      beat_n    = '0;
      ilv_n     = burst_ilv;
    end else if (advance) begin
      beat_n = beat_q + 1'b1;
    end
  end

  assign acc_addr = {base_hi_n, burst_offset(first_n, beat_n, ilv_n)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      base_hi_q <= '0;
      first_q   <= '0;
      beat_q    <= '0;
      ilv_q     <= 1'b0;
    end else begin
      busy_q    <= acc_go;
      base_hi_q <= base_hi_n;
      first_q   <= first_n;
      beat_q    <= beat_n;
      ilv_q     <= ilv_n;
    end
  end
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                       clk,
  input  logic [LANES-1:0]           wr_lanes,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANES*LANE_BITS-1:0] wdata,
  output logic [LANES*LANE_BITS-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] cells [DEPTH];
    logic [LANE_BITS-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) cells[addr] <= wdata[g*LANE_BITS +: LANE_BITS];
      if (rd_en)       rd_q        <= cells[addr];
    end

    assign rdata[g*LANE_BITS +: LANE_BITS] = rd_q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_n,
  input  logic                       strobe_cpu_n,
  input  logic                       strobe_ctl_n,
  input  logic                       adv_n,
  input  logic                       burst_ilv,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       gwr_n,
  input  logic [LANES-1:0]           bwr_n,
  input  logic                       oe_n,
  input  logic [LANES*LANE_BITS-1:0] d,
  output logic [LANES*LANE_BITS-1:0] q,
  output logic                       q_drv
);
  localparam int DATA_W = LANES * LANE_BITS;

  // Named internal events, visible to the bound checker.
  logic              start_cpu, start_any, deselect, advance, busy, order_ilv;
  logic              acc_go, acc_ro;
  logic [ADDR_W-1:0] acc_addr;
  logic              wr_req;
  logic [LANES-1:0]  wr_mask;

  // Stage 1: registered access; stage 2: output register.
  logic              s1_rd, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;
  logic [LANES-1:0]  s1_mask;
  logic [LANES-1:0]  arr_wr_lanes;
  logic [DATA_W-1:0] rd_data;
  logic              q_valid;

  sbs_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .burst_ilv    (burst_ilv),
    .addr         (addr),
    .start_cpu    (start_cpu),
    .start_any    (start_any),
    .deselect     (deselect),
    .advance      (advance),
    .busy         (busy),
    .order_ilv    (order_ilv),
    .acc_go       (acc_go),
    .acc_ro       (acc_ro),
    .acc_addr     (acc_addr)
  );

  assign wr_req  = acc_go & ~acc_ro & (~gwr_n | ~&bwr_n);
  assign wr_mask = gwr_n ? ~bwr_n : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd   <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_data <= '0;
      s1_mask <= '0;
    end else begin
      s1_rd   <= acc_go & ~wr_req;
      s1_wr   <= wr_req;
      s1_addr <= acc_addr;
      s1_data <= d;
      s1_mask <= wr_mask;
    end
  end

  assign arr_wr_lanes = s1_wr ? s1_mask : '0;

  sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk      (clk),
    .wr_lanes (arr_wr_lanes),
    .rd_en    (s1_rd),
    .addr     (s1_addr),
    .wdata    (s1_data),
    .rdata    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= s1_rd;
  end

  assign q     = rd_data;
  assign q_drv = q_valid & ~oe_n;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              strobe_ctl_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              start_cpu,
  input logic              start_any,
  input logic              deselect,
  input logic              advance,
  input logic              busy,
  input logic              order_ilv,
  input logic              s1_rd,
  input logic              s1_wr,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              q_valid,
  input logic              q_drv
);
  a_r2_start_loads_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_any |=> (s1_addr == $past(addr)));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !order_ilv) |=> (s1_addr[1:0] == ($past(s1_addr[1:0]) + 2'd1)));

  a_r5_hold_repeats: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_any && !deselect && adv_n) |=> (s1_addr == $past(s1_addr)));

  a_r8_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    start_cpu |=> (s1_rd && !s1_wr));

  a_r9_cpu_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_n && strobe_ctl_n) |=> (s1_rd || s1_wr));

  a_r11_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    deselect |=> ##1 !q_valid);

  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    s1_wr |=> !q_valid);

  a_r12_oe_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !q_drv);
endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_n        (sel_n),
  .strobe_ctl_n (strobe_ctl_n),
  .adv_n        (adv_n),
  .oe_n         (oe_n),
  .addr         (addr),
  .start_cpu    (start_cpu),
  .start_any    (start_any),
  .deselect     (deselect),
  .advance      (advance),
  .busy         (busy),
  .order_ilv    (order_ilv),
  .s1_rd        (s1_rd),
  .s1_wr        (s1_wr),
  .s1_addr      (s1_addr),
  .q_valid      (q_valid),
  .q_drv        (q_drv)
);

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int LN = 2;
  localparam int DW = LN * 9;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_n, strobe_cpu_n, strobe_ctl_n, adv_n, burst_ilv, gwr_n, oe_n;
  logic [AW-1:0] addr;
  logic [LN-1:0] bwr_n;
  logic [DW-1:0] d;
  logic [DW-1:0] q;
  logic          q_drv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strobe_cpu_n(strobe_cpu_n),
    .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .burst_ilv(burst_ilv),
    .addr(addr), .gwr_n(gwr_n), .bwr_n(bwr_n), .oe_n(oe_n), .d(d),
    .q(q), .q_drv(q_drv)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 7919 + 12345) ^ (a << 9));
  endfunction

  // Behavioural reference model, advanced on every rising edge.
  logic [DW-1:0] mmem [64];
  bit m_busy, m_ilv, s_rd, s_wr, e_valid;
  int m_base, m_beat, s_a;
  logic [DW-1:0] s_d, e_q;
  logic [LN-1:0] s_mask;

  always @(posedge clk) begin
    bit go, ro, wr;
    if (!rst_n) begin
      m_busy = 0; s_rd = 0; s_wr = 0; e_valid = 0;
    end else begin
      e_valid = s_rd;
      if (s_rd) e_q = mmem[s_a];
      if (s_wr)
        for (int l = 0; l < LN; l++)
          if (s_mask[l]) mmem[s_a][l*9 +: 9] = s_d[l*9 +: 9];
      go = 0; ro = 0;
      if (!sel_n && (!strobe_cpu_n || !strobe_ctl_n)) begin
        m_base = int'(addr); m_beat = 0; m_ilv = burst_ilv; m_busy = 1;
        go = 1; ro = !strobe_cpu_n;
      end else if (sel_n && !strobe_ctl_n) begin
        m_busy = 0;
      end else if (m_busy) begin
        if (!adv_n) m_beat = (m_beat + 1) % 4;
        go = 1;
      end
      s_rd = 0; s_wr = 0;
      if (go) begin
        s_a = (m_base / 4) * 4 +
              (m_ilv ? ((m_base % 4) ^ m_beat) : ((m_base % 4 + m_beat) % 4));
        wr = !ro && (!gwr_n || bwr_n != '1);
        s_rd = !wr; s_wr = wr; s_d = d;
        s_mask = !gwr_n ? '1 : ~bwr_n;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_idle();
    sel_n = 0; strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1;
    gwr_n = 1; bwr_n = '1; oe_n = 0;
  endtask

  // One clock: edge, compare with the model, return at the falling edge.
  task automatic step();
    bit exp_drv;
    @(posedge clk);
    #(CLK_PERIOD/4);
    exp_drv = e_valid && !oe_n;
    chk(q_drv == exp_drv, "R2/R11 model q_drv", DW'(q_drv), DW'(exp_drv));
    if (exp_drv) chk(q == e_q, "R2 model q", q, e_q);
    @(negedge clk);
  endtask

  task automatic rd1(input int a, output logic [DW-1:0] v);
    set_idle(); strobe_ctl_n = 0; addr = AW'(a); step();
    set_idle(); step();
    v = q;
  endtask

  task automatic wr1(input int a, input logic [DW-1:0] v, input logic g_n,
                     input logic [LN-1:0] b_n);
    set_idle(); strobe_ctl_n = 0; addr = AW'(a); d = v; gwr_n = g_n; bwr_n = b_n;
    step();
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();
  endtask

  task automatic burst_read(input int start, input bit inter, input bit use_cpu,
                            input string req);
    int ea;
    for (int j = 0; j < 5; j++) begin
      set_idle();
      if (j == 0) begin
        addr = AW'(start); burst_ilv = inter;
        if (use_cpu) strobe_cpu_n = 0; else strobe_ctl_n = 0;
      end else if (j < 4) adv_n = 0;
      step();
      if (j >= 1) begin
        ea = (start & ~3) | (inter ? ((start & 3) ^ (j - 1)) : (((start & 3) + j - 1) & 3));
        chk(q_drv && q == pat(ea), req, q, pat(ea));
      end
    end
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, nv, nv2;
    rst_n = 0; set_idle(); addr = '0; d = '0; burst_ilv = 0;
    repeat (3) @(negedge clk);
    chk(!q_drv, "R1 in reset", DW'(q_drv), '0);
    rst_n = 1;
    step();
    chk(!q_drv, "R1 after reset", DW'(q_drv), '0);

    // Fill the array with a known pattern using global writes (R7).
    for (int a = 0; a < 64; a++) begin
      set_idle(); strobe_ctl_n = 0; addr = AW'(a); gwr_n = 0; d = pat(a); step();
    end
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();

    // R2: latency of a single read.
    set_idle(); strobe_ctl_n = 0; addr = AW'(5); step();
    chk(!q_drv, "R2 not yet", DW'(q_drv), '0);
    set_idle(); step();
    chk(q_drv && q == pat(5), "R2 data", q, pat(5));
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();

    // R3 linear and R4 interleaved, all start offsets, both strobes.
    for (int o = 0; o < 4; o++) burst_read(8 + o, 0, o[0], "R3 linear beat");
    for (int o = 0; o < 4; o++) burst_read(16 + o, 1, o[0], "R4 interleaved beat");
    burst_read(26, 1, 1, "R4 interleaved beat");

    // R5: held advance repeats the address.
    set_idle(); strobe_cpu_n = 0; addr = AW'(13); burst_ilv = 0; step();
    set_idle(); step();
    set_idle(); step();
    chk(q == pat(13), "R5 hold", q, pat(13));
    set_idle(); adv_n = 0; step();
    set_idle(); step();
    chk(q == pat(14), "R5 advance after hold", q, pat(14));
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();

    // R6: per-lane writes.
    nv = 18'h2A5A5; nv2 = 18'h15A5A;
    wr1(30, nv, 1'b1, 2'b10);
    wr1(30, nv2, 1'b1, 2'b01);
    rd1(30, v);
    chk(v == {nv2[17:9], nv[8:0]}, "R6 two lanes", v, {nv2[17:9], nv[8:0]});
    wr1(31, nv, 1'b1, 2'b01);
    rd1(31, v);
    chk(v == {nv[17:9], pat(31)}[17:0] || v == {nv[17:9], pat(31)[8:0]},
        "R6 lane1 only", v, {nv[17:9], pat(31)[8:0]});
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();

    // R7: global write overrides lane enables.
    wr1(33, nv, 1'b0, 2'b11);
    rd1(33, v);
    chk(v == nv, "R7 gw with no lanes", v, nv);
    wr1(34, nv2, 1'b0, 2'b10);
    rd1(34, v);
    chk(v == nv2, "R7 gw with one lane", v, nv2);
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();

    // R8: processor-strobe start ignores write controls.
    set_idle(); strobe_cpu_n = 0; addr = AW'(35); gwr_n = 0; bwr_n = '0; d = nv; step();
    set_idle(); step();
    chk(q_drv && q == pat(35), "R8 start is read", q, pat(35));
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();
    rd1(35, v);
    chk(v == pat(35), "R8 memory unchanged", v, pat(35));
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();

    // R9: processor strobe while deselected is ignored; then R11 deselect.
    set_idle(); strobe_cpu_n = 0; addr = AW'(40); burst_ilv = 0; step();
    set_idle(); adv_n = 0; step();
    set_idle(); sel_n = 1; strobe_cpu_n = 0; adv_n = 0; addr = AW'(50); step();
    set_idle(); step();
    chk(q_drv && q == pat(42), "R9 burst continued", q, pat(42));
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();
    chk(q_drv && q == pat(42), "R11 read still out", q, pat(42));
    set_idle(); step();
    chk(!q_drv, "R11 off after deselect", DW'(q_drv), '0);

    // R10: a strobe mid-burst restarts it.
    set_idle(); strobe_cpu_n = 0; addr = AW'(44); step();
    set_idle(); adv_n = 0; step();
    set_idle(); strobe_ctl_n = 0; addr = AW'(52); step();
    set_idle(); adv_n = 0; step();
    chk(q == pat(52), "R10 restart beat0", q, pat(52));
    set_idle(); step();
    chk(q == pat(53), "R10 restart beat1", q, pat(53));
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();

    // R11: a write turns the output off one edge later.
    rd1(37, v);
    set_idle(); strobe_ctl_n = 0; addr = AW'(36); gwr_n = 0; d = nv2; step();
    set_idle(); step();
    chk(!q_drv, "R11 off after write", DW'(q_drv), '0);
    set_idle(); step();
    chk(q_drv && q == nv2, "R7 written word", q, nv2);

    // R12: output enable acts without a clock edge.
    rd1(38, v);
    oe_n = 1; #1;
    chk(!q_drv, "R12 oe high", DW'(q_drv), '0);
    oe_n = 0; #1;
    chk(q_drv && q == pat(38), "R12 oe low", q, pat(38));
    @(negedge clk);
    set_idle(); sel_n = 1; strobe_ctl_n = 0; step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule